// File: doc/BRIEF.md
# Four-Phase Dynamic Stage Sequencer

This block drives the control strobes for a chain of precharge/evaluate logic stages. Each stage steps through four phases in a fixed loop: precharge, evaluate, a first hold and a second hold. Neighbouring stages run one phase slot apart, so a stage evaluates while its downstream neighbour precharges. The downstream stage then evaluates while the upstream one is in its first hold.

The second hold keeps a stage's result intact until the stage two places downstream has finished evaluating. Only then does the stage precharge again, so a value is consumed before the precharge that would disturb it. A single shared phase counter advances on every enabled clock. Each stage decodes its own phase from that counter and its index. The strobe pattern therefore repeats every four stages.

The minimum control period is four evaluate slots, because there are four distinct evaluate phases per loop. The enable input freezes every stage in its current phase.

Top module: `dyn_phase_seq`

## Requirements
- R1: While the synchronous reset is high at a rising edge, the next state puts stage k in phase (0 - k) mod 4. Phase codes are 0 = precharge, 1 = evaluate, 2 = hold 1, 3 = hold 2. Stage k's phase is shown one-hot on `phase_oh[4k+3:4k]`: bit 0 precharge, bit 1 evaluate, bit 2 hold 1, bit 3 hold 2.
- R2: On each rising edge with enable high and reset low, every stage moves to its next phase: precharge to evaluate, evaluate to hold 1, hold 1 to hold 2, and hold 2 back to precharge.
- R3: Whenever stage i is in evaluate, stage i+1 is in precharge, and the reverse also holds.
- R4: Stages i and i+1 are never in evaluate together.
- R5: Stage i+4 always shows exactly the same phase as stage i.
- R6: Whenever stage i+2 is in evaluate, stage i is in hold 2.
- R7: Each stage has exactly one phase bit set in every cycle. `pre_o[k]` equals phase bit 0 of stage k, and `eva_o[k]` equals phase bit 1.
- R8: On a rising edge with enable low and reset low, no output changes.
- R9: Consider a dynamic stage model in which each node is set to 1 in precharge and copies its upstream node in evaluate. In this model, a token stream fed to stage 0 leaves the last stage unchanged and in order, and no stage is in precharge when its downstream neighbour evaluates.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance enable; low freezes all stages |
| phase_oh | output | 4*NUM_STAGES | One-hot phase of each stage, 4 bits per stage |
| pre_o | output | NUM_STAGES | Precharge strobe per stage |
| eva_o | output | NUM_STAGES | Evaluate strobe per stage |

## Verification
The hardest case to reach is the token handoff when enable drops while a stage sits in evaluate. A frozen evaluate repeats the same read. Any slip in the phase offsets would then let the upstream node precharge before the downstream read, and the stream would be corrupted. The stimulus runs long enable-high stretches, periodic and pseudo-random enable gaps, and a reset in the middle of a run. Meanwhile a bench-side dynamic-node model moves tokens through eight stages. Eight stages is enough for every stage offset and the four-stage repeat to appear twice.

// File: rtl/dyn_seq_pkg.sv
package dyn_seq_pkg;
  localparam int PH_NUM = 4;
  localparam int PH_W   = $clog2(PH_NUM);

  typedef enum logic [PH_W-1:0] {
    PH_PRE  = 2'd0,
    PH_EVA  = 2'd1,
    PH_HLD1 = 2'd2,
    PH_HLD2 = 2'd3
  } phase_e;

  // phase of a lane: shared counter lagged by the lane index
  function automatic logic [PH_W-1:0] lane_phase(input logic [PH_W-1:0] base, input int idx);
    logic [PH_W-1:0] off;
    off = PH_W'(idx % PH_NUM);
    return base - off;
  endfunction

  function automatic logic [PH_NUM-1:0] phase_onehot(input logic [PH_W-1:0] ph);
    return PH_NUM'(1) << ph;
  endfunction
endpackage

// File: rtl/dyn_phase_ring.sv
module dyn_phase_ring
  import dyn_seq_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  output logic [PH_W-1:0] base_o
);
  always_ff @(posedge clk) begin
    if (rst)     base_o <= '0;
    else if (en) base_o <= base_o + 1'b1;
  end

  // R2
  ring_step_chk: assert property (@(posedge clk) disable iff (rst)
    en |=> base_o == PH_W'($past(base_o) + 1'b1));
  // R8
  ring_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(base_o));
endmodule

// File: rtl/dyn_lane_decode.sv
module dyn_lane_decode
  import dyn_seq_pkg::*;
#(
  parameter int IDX = 0
) (
  input  logic [PH_W-1:0]   base_i,
  output logic [PH_NUM-1:0] ph_oh_o,
  output logic              pre_o,
  output logic              eva_o
);
  phase_e ph;

  assign ph      = phase_e'(lane_phase(base_i, IDX));
  assign ph_oh_o = phase_onehot(ph);
  assign pre_o   = (ph == PH_PRE);
  assign eva_o   = (ph == PH_EVA);
endmodule

// File: rtl/dyn_phase_seq.sv
module dyn_phase_seq
  import dyn_seq_pkg::*;
#(
  parameter int NUM_STAGES = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         en,
  output logic [PH_NUM*NUM_STAGES-1:0] phase_oh,
  output logic [NUM_STAGES-1:0]        pre_o,
  output logic [NUM_STAGES-1:0]        eva_o
);
  localparam int OH_W = PH_NUM * NUM_STAGES;

  logic [PH_W-1:0] base_w;

  dyn_phase_ring u_ring (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .base_o (base_w)
  );

  for (genvar k = 0; k < NUM_STAGES; k++) begin : g_lane
    dyn_lane_decode #(.IDX(k)) u_lane (
      .base_i  (base_w),
      .ph_oh_o (phase_oh[PH_NUM*k +: PH_NUM]),
      .pre_o   (pre_o[k]),
      .eva_o   (eva_o[k])
    );

    // R7
    lane_onehot_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot(phase_oh[PH_NUM*k +: PH_NUM]));
    // R7
    lane_strobe_chk: assert property (@(posedge clk) disable iff (rst)
      (pre_o[k] == phase_oh[PH_NUM*k]) && (eva_o[k] == phase_oh[PH_NUM*k+1]));
    // R2
    pre_to_eva_chk: assert property (@(posedge clk) disable iff (rst)
      (en && pre_o[k]) |=> eva_o[k]);
    // R2
    hld2_to_pre_chk: assert property (@(posedge clk) disable iff (rst)
      (en && phase_oh[PH_NUM*k+3]) |=> pre_o[k]);

    if (k + 1 < NUM_STAGES) begin : g_nbr
      // R3
      eva_pre_align_chk: assert property (@(posedge clk) disable iff (rst)
        eva_o[k] == pre_o[k+1]);
      // R4
      no_dual_eva_chk: assert property (@(posedge clk) disable iff (rst)
        !(eva_o[k] && eva_o[k+1]));
    end
    if (k + 2 < NUM_STAGES) begin : g_two
      // R6
      used_before_pre_chk: assert property (@(posedge clk) disable iff (rst)
        eva_o[k+2] |-> phase_oh[PH_NUM*k+3]);
    end
    if (k + 4 < NUM_STAGES) begin : g_rep
      // R5
      period_four_chk: assert property (@(posedge clk) disable iff (rst)
        phase_oh[PH_NUM*k +: PH_NUM] == phase_oh[PH_NUM*(k+4) +: PH_NUM]);
    end
  end

  // R8
  freeze_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(phase_oh[OH_W-1:0]));
  // R1
  reset_pre0_chk: assert property (@(posedge clk)
    rst |=> pre_o[0]);
endmodule

// File: tb/sim_dyn_phase_seq.sv
`timescale 1ns/1ps
module sim_dyn_phase_seq;
  localparam int NS = 8;
  localparam int WATCH = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic [4*NS-1:0] phase_oh;
  logic [NS-1:0]   pre_o, eva_o;

  always #2 clk = ~clk;

  dyn_phase_seq #(.NUM_STAGES(NS)) u0 (
    .clk(clk), .rst(rst), .en(en),
    .phase_oh(phase_oh), .pre_o(pre_o), .eva_o(eva_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  int exp_cnt = 0;
  bit done = 1'b0;

  // dynamic node model
  logic [NS-1:0] node_d = '1;
  logic [NS-1:0] node_v = '0;
  logic tok_cur = 1'b0;
  logic [7:0] tok_lfsr = 8'h5A;
  logic qbuf [0:1023];
  int qh = 0, qt = 0;
  int popped = 0;

  function automatic logic [4*NS-1:0] exp_vec(input int c);
    logic [4*NS-1:0] v = '0;
    for (int k = 0; k < NS; k++) begin
      int ph = (c - k) & 3;
      v[4*k + ph] = 1'b1;
    end
    return v;
  endfunction

  task automatic note(input bit ok, input string tag, input string what, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  task automatic check_state(input string tag);
    logic [4*NS-1:0] e;
    e = exp_vec(exp_cnt);
    note(phase_oh == e, tag, "phase vector", longint'(phase_oh), longint'(e));
    begin
      bit ok3 = 1, ok4 = 1, ok5 = 1, ok6 = 1, ok7 = 1;
      for (int k = 0; k < NS; k++) begin
        if ($countones(phase_oh[4*k +: 4]) != 1) ok7 = 0;
        if (pre_o[k] != phase_oh[4*k] || eva_o[k] != phase_oh[4*k+1]) ok7 = 0;
        if (k + 1 < NS && eva_o[k] != pre_o[k+1]) ok3 = 0;
        if (k + 1 < NS && eva_o[k] && eva_o[k+1]) ok4 = 0;
        if (k + 2 < NS && eva_o[k+2] && !phase_oh[4*k+3]) ok6 = 0;
        if (k + 4 < NS && phase_oh[4*k +: 4] != phase_oh[4*(k+4) +: 4]) ok5 = 0;
      end
      note(ok3, "R3", "eva/pre neighbour alignment", longint'(eva_o), longint'(pre_o));
      note(ok4, "R4", "neighbour dual evaluate", longint'(eva_o), 0);
      note(ok5, "R5", "four-stage repeat", longint'(phase_oh), longint'(e));
      note(ok6, "R6", "hold 2 under i+2 evaluate", longint'(phase_oh), longint'(e));
      note(ok7, "R7", "one-hot and strobes", longint'({pre_o, eva_o}), longint'(e));
    end
  endtask

  // called at a negedge; leaves at the next negedge after checking
  task automatic step(input logic en_v, input logic rst_v, input string tag);
    logic [NS-1:0] ps, es, nd, nv;
    en = en_v; rst = rst_v;
    ps = pre_o; es = eva_o;
    @(posedge clk);
    if (rst_v) begin
      exp_cnt = 0;
      node_d = '1; node_v = '0; qh = 0; qt = 0;
    end else begin
      if (en_v) exp_cnt++;
      nd = node_d; nv = node_v;
      for (int k = 0; k < NS; k++) begin
        if (ps[k]) begin
          nd[k] = 1'b1; nv[k] = 1'b0;
        end else if (es[k]) begin
          nd[k] = (k == 0) ? tok_cur : node_d[k-1];
          nv[k] = (k == 0) ? 1'b1 : node_v[k-1];
          if (k > 0 && en_v)
            note(!ps[k-1], "R9", "upstream precharged during handoff", longint'(ps), 0);
        end
      end
      if (en_v && es[NS-1] && node_v[NS-2]) begin
        note(qh != qt && node_d[NS-2] == qbuf[qh[9:0]], "R9", "token out of last stage",
             longint'(node_d[NS-2]), longint'(qbuf[qh[9:0]]));
        if (qh != qt) qh++;
        popped++;
      end
      if (en_v && es[0]) begin
        qbuf[qt[9:0]] = tok_cur; qt++;
        tok_lfsr = {tok_lfsr[6:0], tok_lfsr[7] ^ tok_lfsr[5] ^ tok_lfsr[4] ^ tok_lfsr[3]};
        tok_cur = tok_lfsr[0];
      end
      node_d = nd; node_v = nv;
    end
    @(negedge clk);
    check_state(tag);
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    logic [7:0] pat;
    @(negedge clk);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, "R1");
    for (int i = 0; i < 40; i++) step(1'b1, 1'b0, "R2");
    for (int i = 0; i < 40; i++) step(i[0], 1'b0, i[0] ? "R2" : "R8");
    for (int i = 0; i < 60; i++) step((i % 3) != 0, 1'b0, ((i % 3) != 0) ? "R2" : "R8");
    for (int i = 0; i < 12; i++) step(1'b0, 1'b0, "R8");
    pat = 8'hC3;
    for (int i = 0; i < 240; i++) begin
      pat = {pat[6:0], pat[7] ^ pat[5] ^ pat[4] ^ pat[3]};
      step(pat[0] | pat[1], 1'b0, (pat[0] | pat[1]) ? "R2" : "R8");
    end
    step(1'b0, 1'b1, "R1");
    step(1'b1, 1'b1, "R1");
    for (int i = 0; i < 40; i++) step(1'b1, 1'b0, "R2");
    note(popped > 20, "R9", "tokens delivered", popped, 21);
    done = 1'b1;
    report();
  end

  initial begin
    repeat (WATCH) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      report();
    end
  end
endmodule